// File: doc/BRIEF.md
# AUX Native Transaction Requester

This block turns a host request for a native register read or write on a display side channel into a framed byte message, pushes it to a link-layer port over a valid/ready byte stream, and then interprets what the link layer reports back. The host gives a 16-bit register address, the direction, a byte count of 1 to 16 and, for writes, the payload. The block prefixes the payload with a four-byte header, sends it, collects any reply bytes, and reads the transfer status and the reply field that close the attempt.

Retries are layered. A link-layer busy status resends the whole message in the very next cycle. A deferred reply first waits a fixed 400 microseconds, counted in clock cycles from a clock-frequency parameter, and then resends. Timeouts, generic errors, negative acknowledgements and malformed replies end the transaction at once. No more than four attempts are made. The host sees a busy flag, a one-cycle done pulse, a result code, a byte count and the read data.

Top module: `aux_native_requester`

## Requirements
- R1: The first three bytes sent are the low address byte, the high address byte, and the command byte, whose upper nibble is 8 for a write and 9 for a read and whose lower nibble is 0.
- R2: The fourth byte sent has the message length (4 for a read, 4 plus the byte count for a write, taken modulo 16) in its upper nibble and the byte count minus one in its lower nibble; a write then sends its payload bytes, payload byte k taken from wdata bits 8k+7:8k.
- R3: A start whose byte count is 0 or above 16 sends nothing and raises done on the next cycle with result 5 and count 0.
- R4: At most four attempts are made; a busy status on the fourth attempt ends with result 2, a deferred reply on the fourth attempt ends with result 4.
- R5: A status of 2 (busy) on attempts one to three resends the complete message starting in the cycle after the status, with no wait.
- R6: A status of 1 (timeout) ends with result 1, and a status of 3 (error) ends with result 4, both with count 0.
- R7: A status of 0 with reply code 0 (acknowledge) ends with result 0; the count is the byte count for a write and, for a read, the lesser of the bytes received in that attempt and the byte count. done is high for exactly one cycle.
- R8: A status of 0 with reply code 2 (defer) before the last attempt holds tx_valid low for exactly 400 microseconds of clock cycles before resending; reply code 1 ends with result 3, reply code 3 ends with result 4.
- R9: The k-th reply byte of an attempt lands in rdata bits 8k+7:8k; bytes beyond the byte count are dropped, and a reply byte presented in the same cycle as the status still counts.
- R10: While tx_valid is high and tx_ready low, tx_data and tx_last hold; tx_last marks only the final byte; a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction when idle |
| rd | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Register address |
| len | input | 5 | Byte count (1 to 16 valid) |
| wdata | input | 128 | Write payload, byte k at bits 8k+7:8k |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 timeout, 2 busy exhausted, 3 nack, 4 I/O error, 5 bad length |
| count | output | 5 | Bytes transferred on success |
| rdata | output | 128 | Read data, byte k at bits 8k+7:8k |
| tx_data | output | 8 | Message byte to link layer |
| tx_valid | output | 1 | Message byte valid |
| tx_last | output | 1 | Final message byte |
| tx_ready | input | 1 | Link layer accepts byte |
| rx_data | input | 8 | Reply data byte |
| rx_valid | input | 1 | Reply data byte valid |
| rsp_valid | input | 1 | Attempt status valid |
| rsp_status | input | 2 | 0 done, 1 timeout, 2 busy, 3 error |
| rsp_code | input | 2 | Reply field: 0 ack, 1 nack, 2 defer, 3 invalid |

## Verification
Two functions that can meet in one cycle are the capture of a reply data byte and the retry decision made on the attempt status. The bench presents the final reply byte in the same cycle as an acknowledge status, once with fewer bytes than requested and once with more, and judges the reported count and the placement of each byte in rdata against the requested count. A second collision, a fresh start arriving while the block waits for a status, is provoked with a deliberately illegal length and judged by the result still being a success and no further message appearing.

// File: rtl/aux_native_requester.sv
module aux_native_requester #(
  parameter int CLK_HZ    = 50_000_000,
  parameter int DEFER_US  = 400,
  parameter int MAX_TRIES = 4,
  parameter int MAX_BYTES = 16
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   rd,
  input  logic [15:0]            addr,
  input  logic [4:0]             len,
  input  logic [8*MAX_BYTES-1:0] wdata,
  output logic                   busy,
  output logic                   done,
  output logic [2:0]             result,
  output logic [4:0]             count,
  output logic [8*MAX_BYTES-1:0] rdata,
  output logic [7:0]             tx_data,
  output logic                   tx_valid,
  output logic                   tx_last,
  input  logic                   tx_ready,
  input  logic [7:0]             rx_data,
  input  logic                   rx_valid,
  input  logic                   rsp_valid,
  input  logic [1:0]             rsp_status,
  input  logic [1:0]             rsp_code
);
  localparam int BW        = $clog2(MAX_BYTES);
  localparam int IW        = $clog2(MAX_BYTES + 5);
  localparam int TW        = $clog2(MAX_TRIES);
  localparam int DEFER_CYC = (CLK_HZ / 1_000_000) * DEFER_US;
  localparam int WW        = $clog2(DEFER_CYC + 1);

  localparam logic [2:0] RES_OK = 3'd0, RES_TMO = 3'd1, RES_BSY = 3'd2,
                         RES_NAK = 3'd3, RES_IOE = 3'd4, RES_LEN = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_DEFER} st_t;
  typedef enum logic [1:0] {A_NONE, A_DONE, A_RETRY, A_DEFER} act_t;

  st_t            st;
  logic [15:0]    addr_q;
  logic           rd_q;
  logic [4:0]     len_q;
  logic [7:0]     wbuf [MAX_BYTES];
  logic [7:0]     rbuf [MAX_BYTES];
  logic [IW-1:0]  idx;
  logic [4:0]     rxcnt;
  logic [TW-1:0]  tries;
  logic [WW-1:0]  wcnt;
  act_t           act;
  logic [2:0]     code;

  wire            len_bad  = (len == 5'd0) || (len > 5'(MAX_BYTES));
  wire [IW-1:0]   msg_len  = rd_q ? IW'(4) : IW'(len_q) + IW'(4);
  wire [BW-1:0]   pidx     = BW'(idx - IW'(4));
  wire            last_try = (tries == TW'(MAX_TRIES - 1));
  wire            rx_take  = (st == S_WAIT) && rx_valid;
  wire [4:0]      rxcnt_nx = rxcnt + ((rx_take && rxcnt != 5'h1f) ? 5'd1 : 5'd0);
  wire [4:0]      rd_cnt   = (rxcnt_nx < len_q) ? rxcnt_nx : len_q;

  assign busy     = (st != S_IDLE);
  assign tx_valid = (st == S_SEND);
  assign tx_last  = tx_valid && (idx == msg_len - IW'(1));

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_rd
    assign rdata[8*g +: 8] = rbuf[g];
  end

  always_comb begin
    case (idx)
      IW'(0):  tx_data = addr_q[7:0];
      IW'(1):  tx_data = addr_q[15:8];
      IW'(2):  tx_data = {(rd_q ? 4'h9 : 4'h8), 4'h0};
      IW'(3):  tx_data = {msg_len[3:0], len_q[3:0] - 4'd1};
      default: tx_data = wbuf[pidx];
    endcase
  end

  always_comb begin
    act  = A_NONE;
    code = RES_OK;
    if (st == S_WAIT && rsp_valid) begin
      act = A_DONE;
      case (rsp_status)
        2'd0: case (rsp_code)
                2'd0: code = RES_OK;
                2'd1: code = RES_NAK;
                2'd2: if (last_try) code = RES_IOE; else act = A_DEFER;
                default: code = RES_IOE;
              endcase
        2'd1: code = RES_TMO;
        2'd2: if (last_try) code = RES_BSY; else act = A_RETRY;
        default: code = RES_IOE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      result <= RES_OK;
      count  <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      len_q  <= '0;
      idx    <= '0;
      rxcnt  <= '0;
      tries  <= '0;
      wcnt   <= '0;
      for (int i = 0; i < MAX_BYTES; i++) begin
        wbuf[i] <= '0;
        rbuf[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (len_bad) begin
            done   <= 1'b1;
            result <= RES_LEN;
            count  <= '0;
          end else begin
            st     <= S_SEND;
            addr_q <= addr;
            rd_q   <= rd;
            len_q  <= len;
            idx    <= '0;
            tries  <= '0;
            for (int i = 0; i < MAX_BYTES; i++) begin
              wbuf[i] <= wdata[8*i +: 8];
              rbuf[i] <= '0;
            end
          end
        end
        S_SEND: if (tx_ready) begin
          if (tx_last) begin
            st    <= S_WAIT;
            rxcnt <= '0;
          end else begin
            idx <= idx + IW'(1);
          end
        end
        S_WAIT: begin
          if (rx_take && rxcnt < len_q) rbuf[rxcnt[BW-1:0]] <= rx_data;
          rxcnt <= rxcnt_nx;
          case (act)
            A_DONE: begin
              st     <= S_IDLE;
              done   <= 1'b1;
              result <= code;
              count  <= (code != RES_OK) ? 5'd0 : (rd_q ? rd_cnt : len_q);
            end
            A_RETRY: begin
              st    <= S_SEND;
              idx   <= '0;
              tries <= tries + TW'(1);
            end
            A_DEFER: begin
              st    <= S_DEFER;
              wcnt  <= '0;
              tries <= tries + TW'(1);
            end
            default: ;
          endcase
        end
        S_DEFER: begin
          if (wcnt == WW'(DEFER_CYC - 1)) begin
            st  <= S_SEND;
            idx <= '0;
          end else begin
            wcnt <= wcnt + WW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_data == addr_q[7:0]); // R1
  AST_BAD_LEN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && len_bad) |=> (done && result == RES_LEN && !tx_valid)); // R3
  AST_DEFER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && rsp_valid && rsp_status == 2'd0 && rsp_code == 2'd2 && last_try)
    |=> (done && result == RES_IOE)); // R4
  AST_BUSY_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && rsp_valid && rsp_status == 2'd2 && !last_try)
    |=> (tx_valid && tx_data == addr_q[7:0])); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_OK) |-> (count <= len_q)); // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R10
endmodule

// File: tb/aux_native_requester_test.sv
module aux_native_requester_test;
  localparam int DEFER_CYC = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [4:0] len = '0;
  logic [127:0] wdata = '0;
  logic busy, done, tx_valid, tx_last;
  logic [2:0] result;
  logic [4:0] count;
  logic [127:0] rdata;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1;
  logic [7:0] rx_data = '0;
  logic rx_valid = 1'b0, rsp_valid = 1'b0;
  logic [1:0] rsp_status = '0, rsp_code = '0;

  int checks = 0, fails = 0;
  logic [7:0] capt [32];
  int ncapt, gap;
  bit stall = 1'b0;

  always #10 clk = ~clk;

  aux_native_requester uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd(rd), .addr(addr), .len(len),
    .wdata(wdata), .busy(busy), .done(done), .result(result), .count(count),
    .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_code(rsp_code));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic begin_txn(input bit r, input logic [15:0] a, input logic [4:0] n, input logic [127:0] w);
    @(negedge clk);
    start = 1'b1; rd = r; addr = a; len = n; wdata = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic serve;
    bit tog = 1'b0;
    ncapt = 0; gap = 0;
    forever begin
      tog = ~tog;
      tx_ready = stall ? tog : 1'b1;
      if (tx_valid) begin
        if (tx_ready) begin
          capt[ncapt] = tx_data;
          ncapt++;
          if (tx_last) begin
            @(negedge clk);
            tx_ready = 1'b1;
            return;
          end
        end
      end else if (ncapt == 0) gap++;
      @(negedge clk);
    end
  endtask

  task automatic reply(input int nrx, input logic [7:0] base, input bit same, input logic [1:0] st, input logic [1:0] cd);
    for (int i = 0; i < nrx; i++) begin
      rx_valid = 1'b1; rx_data = base + 8'(i);
      if (same && i == nrx - 1) begin rsp_valid = 1'b1; rsp_status = st; rsp_code = cd; end
      @(negedge clk);
    end
    rx_valid = 1'b0;
    if (!(same && nrx > 0)) begin
      rsp_valid = 1'b1; rsp_status = st; rsp_code = cd;
      @(negedge clk);
    end
    rsp_valid = 1'b0;
  endtask

  task automatic check_hdr(input string req, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    chk(capt[0] == b0 && capt[1] == b1 && capt[2] == b2, req, {capt[0], capt[1], capt[2]}, {b0, b1, b2});
    chk(capt[3] == b3, "R2", capt[3], b3);
  endtask

  task automatic check_end(input string req, input logic [2:0] r, input logic [4:0] c);
    chk(done === 1'b1, req, done, 1);
    chk(result == r && count == c, req, {result, count}, {r, c});
  endtask

  task automatic t_reset;
    chk(busy === 1'b0 && done === 1'b0 && tx_valid === 1'b0, "R10", {busy, done, tx_valid}, 0);
  endtask

  task automatic t_write3;
    begin_txn(1'b0, 16'h0123, 5'd3, 128'hA2A1A0);
    serve();
    chk(ncapt == 7, "R2", ncapt, 7);
    check_hdr("R1", 8'h23, 8'h01, 8'h80, 8'h72);
    chk(capt[4] == 8'hA0 && capt[5] == 8'hA1 && capt[6] == 8'hA2, "R2", {capt[4], capt[5], capt[6]}, 24'hA0A1A2);
    reply(0, 8'h0, 1'b0, 2'd0, 2'd0);
    check_end("R7", 3'd0, 5'd3);
    @(negedge clk);
    chk(done === 1'b0, "R7", done, 0);
  endtask

  task automatic t_write16_stall;
    logic [127:0] w;
    for (int i = 0; i < 16; i++) w[8*i +: 8] = 8'h10 + 8'(i);
    stall = 1'b1;
    begin_txn(1'b0, 16'hBEEF, 5'd16, w);
    serve();
    stall = 1'b0;
    chk(ncapt == 20, "R10", ncapt, 20);
    check_hdr("R1", 8'hEF, 8'hBE, 8'h80, 8'h4F);
    for (int i = 0; i < 16; i++)
      chk(capt[4+i] == 8'h10 + 8'(i), "R10", capt[4+i], 8'h10 + 8'(i));
    reply(0, 8'h0, 1'b0, 2'd0, 2'd0);
    check_end("R7", 3'd0, 5'd16);
  endtask

  task automatic t_read_trunc;
    begin_txn(1'b1, 16'h0600, 5'd2, '0);
    serve();
    chk(ncapt == 4, "R2", ncapt, 4);
    check_hdr("R1", 8'h00, 8'h06, 8'h90, 8'h41);
    reply(4, 8'h30, 1'b1, 2'd0, 2'd0);
    check_end("R9", 3'd0, 5'd2);
    chk(rdata[31:0] == 32'h00003130, "R9", rdata[31:0], 32'h3130);
  endtask

  task automatic t_read_coincide;
    begin_txn(1'b1, 16'h0202, 5'd4, '0);
    serve();
    reply(3, 8'h50, 1'b1, 2'd0, 2'd0);
    check_end("R9", 3'd0, 5'd3);
    chk(rdata[31:0] == 32'h00525150, "R9", rdata[31:0], 32'h525150);
  endtask

  task automatic t_bad_len(input logic [4:0] n);
    bit seen = 1'b0;
    begin_txn(1'b0, 16'h0010, n, '1);
    check_end("R3", 3'd5, 5'd0);
    for (int i = 0; i < 8; i++) begin
      if (tx_valid) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen && !busy, "R3", {seen, busy}, 0);
  endtask

  task automatic t_busy_recover;
    begin_txn(1'b1, 16'h0101, 5'd1, '0);
    for (int k = 0; k < 3; k++) begin
      serve();
      chk(k == 0 || gap == 0, "R5", gap, 0);
      chk(ncapt == 4 && capt[0] == 8'h01 && capt[3] == 8'h40, "R5", {capt[0], capt[3]}, 16'h0140);
      reply(0, 8'h0, 1'b0, 2'd2, 2'd0);
    end
    serve();
    chk(gap == 0, "R5", gap, 0);
    reply(1, 8'h77, 1'b1, 2'd0, 2'd0);
    check_end("R4", 3'd0, 5'd1);
    chk(rdata[7:0] == 8'h77, "R9", rdata[7:0], 8'h77);
  endtask

  task automatic t_busy_exhaust;
    begin_txn(1'b0, 16'h0303, 5'd1, 128'h5);
    for (int k = 0; k < 4; k++) begin
      serve();
      reply(0, 8'h0, 1'b0, 2'd2, 2'd0);
    end
    check_end("R4", 3'd2, 5'd0);
    chk(tx_valid === 1'b0, "R4", tx_valid, 0);
  endtask

  task automatic t_fatal(input logic [1:0] st, input logic [1:0] cd, input logic [2:0] r, input string req);
    begin_txn(1'b0, 16'h0404, 5'd2, 128'h1);
    serve();
    reply(0, 8'h0, 1'b0, st, cd);
    check_end(req, r, 5'd0);
    @(negedge clk);
    chk(!busy && !tx_valid, req, {busy, tx_valid}, 0);
  endtask

  task automatic t_defer_ack;
    begin_txn(1'b0, 16'h0505, 5'd1, 128'h9);
    serve();
    reply(0, 8'h0, 1'b0, 2'd0, 2'd2);
    serve();
    chk(gap == DEFER_CYC, "R8", gap, DEFER_CYC);
    chk(capt[0] == 8'h05 && capt[4] == 8'h09, "R8", {capt[0], capt[4]}, 16'h0509);
    reply(0, 8'h0, 1'b0, 2'd0, 2'd0);
    check_end("R8", 3'd0, 5'd1);
  endtask

  task automatic t_defer_exhaust;
    begin_txn(1'b1, 16'h0606, 5'd1, '0);
    for (int k = 0; k < 4; k++) begin
      serve();
      reply(0, 8'h0, 1'b0, 2'd0, 2'd2);
    end
    check_end("R4", 3'd4, 5'd0);
  endtask

  task automatic t_start_ignored;
    bit seen = 1'b0;
    begin_txn(1'b1, 16'h0707, 5'd2, '0);
    serve();
    start = 1'b1; len = 5'd17; addr = 16'hFFFF;
    @(negedge clk);
    start = 1'b0;
    reply(2, 8'h60, 1'b0, 2'd0, 2'd0);
    check_end("R10", 3'd0, 5'd2);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tx_valid || busy) seen = 1'b1;
    end
    chk(!seen, "R10", seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write3();
    t_write16_stall();
    t_read_trunc();
    t_read_coincide();
    t_bad_len(5'd17);
    t_bad_len(5'd0);
    t_busy_recover();
    t_busy_exhaust();
    t_fatal(2'd1, 2'd0, 3'd1, "R6");
    t_fatal(2'd3, 2'd0, 3'd4, "R6");
    t_fatal(2'd0, 2'd1, 3'd3, "R8");
    t_fatal(2'd0, 2'd3, 3'd4, "R8");
    t_defer_ack();
    t_defer_exhaust();
    t_start_ignored();
    summary();
    $finish;
  end
endmodule